// File: doc/BRIEF.md
# Carry-Select Adder with Add-One Converter

This block is a purely combinational binary adder for two W-bit operands and a carry-in. It returns a W-bit sum and a carry-out. The operand bits are cut into groups. Each group above the lowest one works out its result twice: once for an incoming carry of 0 and once for an incoming carry of 1. The carry arriving from the group below then picks one of the two results.

The carry-zero result comes from a ripple-carry adder. In the default variant, the carry-one result is not built by a second ripple adder. It is obtained by adding one to the (n+1)-bit word formed from the carry-zero carry and sum, using a chain of XOR and AND gates. A second variant keeps the classic pair of ripple adders so the two can be compared. It must give bit-identical outputs.

Group sizes follow one of two schemes. Linear grouping uses equal groups of LIN_W bits. Square-root grouping uses widths 2, 2, 3, 4, and so on, so that later groups, whose carry arrives late, do more work in parallel. In both schemes the top group is trimmed to fit W.

Top module: `csel_add`

## Requirements
- R1: For every input, {cout_o, sum_o} equals a_i + b_i + cin_i evaluated on W+1 bits.
- R2: With MODE = GRP_LINEAR, group k covers bits [k*LIN_W +: LIN_W], trimmed at W. Its carry-out is the true carry out of bit k*LIN_W+LIN_W-1.
- R3: With MODE = GRP_SQRT, group widths are 2, 2, 3, 4, 5, ... and the last group is trimmed. For W = 16 the boundaries fall above bits 1, 3, 6 and 10. The group spanning bits [3:2] is steered by the carry out of bit 1.
- R4: In every group above the lowest, the carry-one result equals the carry-zero {carry, sum} word plus one. Its carry is therefore 1 exactly when the carry-zero carry is 1 or the carry-zero sum is all ones.
- R5: A group whose incoming carry is 0 delivers the carry-zero sum and carry. A group whose incoming carry is 1 delivers the carry-one sum and carry.
- R6: The lowest group is a single ripple adder fed directly by cin_i. With a_i = b_i = 0 and cin_i = 1, the output is sum 1 and cout 0.
- R7: VARIANT = SEL_DUAL (two ripple adders per group) and VARIANT = SEL_BEC give identical outputs for identical inputs and grouping.
- R8: When a_i ^ b_i is all ones and cin_i = 1, the carry travels through every group: sum_o is 0 and cout_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | W | Sum bits |
| cout_o | output | 1 | Carry out of bit W-1 |

## Verification
A fault in a group's add-one path or its select stage corrupts only the sum bits at and above that group's lowest bit. It also corrupts the carry handed upward. The fault shows only for inputs whose carry into that group is 1. Because the block has no storage, the error is at the ports in the same cycle the inputs are applied. Stimulus therefore places runs of carry-propagating ones and single generated carries at every bit position, so that each group boundary is crossed with both carry values. Random vectors and the full-propagation case follow, on several widths and both grouping schemes.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;

  typedef enum logic {GRP_LINEAR = 1'b0, GRP_SQRT = 1'b1} grp_mode_e;
  typedef enum logic {SEL_BEC = 1'b0, SEL_DUAL = 1'b1} sel_var_e;

  // nominal width of group g before trimming
  function automatic int grp_nom(grp_mode_e m, int lin_w, int g);
    if (m == GRP_LINEAR) return lin_w;
    return (g == 0) ? 2 : g + 1;
  endfunction

  function automatic int grp_lsb(int w, grp_mode_e m, int lin_w, int g);
    int p;
    p = 0;
    for (int k = 0; k < g; k++) begin
      p += grp_nom(m, lin_w, k);
      if (p > w) p = w;
    end
    return p;
  endfunction

  function automatic int grp_wid(int w, grp_mode_e m, int lin_w, int g);
    int r;
    int n;
    r = w - grp_lsb(w, m, lin_w, g);
    n = grp_nom(m, lin_w, g);
    return (n < r) ? n : r;
  endfunction

  function automatic int grp_cnt(int w, grp_mode_e m, int lin_w);
    int p;
    int n;
    p = 0;
    n = 0;
    while (p < w) begin
      p += grp_nom(m, lin_w, n);
      n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/csel_rca.sv
`timescale 1ns/1ps
module csel_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  output logic [W-1:0] sum_o,
  output logic         co_o
);

  logic [W:0] c;

  always_comb begin
    c[0] = ci_i;
    for (int i = 0; i < W; i++) begin
      sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
      c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
    end
  end

  assign co_o = c[W];

endmodule

// File: rtl/csel_inc.sv
`timescale 1ns/1ps
// adds one to in_i: bit i flips when all lower bits are set
module csel_inc #(
  parameter int W = 3
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);

  logic [W:0] run;

  always_comb begin
    run[0] = 1'b1;
    for (int i = 0; i < W; i++) begin
      out_o[i] = in_i[i] ^ run[i];
      run[i+1] = run[i] & in_i[i];
    end
  end

endmodule

// File: rtl/csel_grp.sv
`timescale 1ns/1ps
module csel_grp #(
  parameter int                 GW      = 4,
  parameter csel_pkg::sel_var_e VARIANT = csel_pkg::SEL_BEC
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          ci_i,
  output logic [GW-1:0] sum_o,
  output logic          co_o,
  output logic          z_co_o,
  output logic          o_co_o
);

  logic [GW-1:0] z_sum;
  logic          z_co;
  logic [GW-1:0] o_sum;
  logic          o_co;

  csel_rca #(.W(GW)) i_rca_z (
    .a_i  (a_i),
    .b_i  (b_i),
    .ci_i (1'b0),
    .sum_o(z_sum),
    .co_o (z_co)
  );

  if (VARIANT == csel_pkg::SEL_BEC) begin : g_bec
    csel_inc #(.W(GW + 1)) i_inc (
      .in_i ({z_co, z_sum}),
      .out_o({o_co, o_sum})
    );
  end else begin : g_dual
    csel_rca #(.W(GW)) i_rca_o (
      .a_i  (a_i),
      .b_i  (b_i),
      .ci_i (1'b1),
      .sum_o(o_sum),
      .co_o (o_co)
    );
  end

  assign {co_o, sum_o} = ci_i ? {o_co, o_sum} : {z_co, z_sum};
  assign z_co_o = z_co;
  assign o_co_o = o_co;

endmodule

// File: rtl/csel_add.sv
`timescale 1ns/1ps
module csel_add #(
  parameter int                  W       = 16,
  parameter csel_pkg::grp_mode_e MODE    = csel_pkg::GRP_SQRT,
  parameter int                  LIN_W   = 4,
  parameter csel_pkg::sel_var_e  VARIANT = csel_pkg::SEL_BEC
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  localparam int NG = csel_pkg::grp_cnt(W, MODE, LIN_W);

  logic [NG:0]   grp_c;
  logic [NG-1:0] grp_z;
  logic [NG-1:0] grp_o;

  assign grp_c[0] = cin_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LSB = csel_pkg::grp_lsb(W, MODE, LIN_W, g);
    localparam int GW  = csel_pkg::grp_wid(W, MODE, LIN_W, g);
    if (g == 0) begin : g_low
      csel_rca #(.W(GW)) i_rca (
        .a_i  (a_i[LSB +: GW]),
        .b_i  (b_i[LSB +: GW]),
        .ci_i (grp_c[0]),
        .sum_o(sum_o[LSB +: GW]),
        .co_o (grp_c[1])
      );
      assign grp_z[0] = grp_c[1];
      assign grp_o[0] = grp_c[1];
    end else begin : g_sel
      csel_grp #(.GW(GW), .VARIANT(VARIANT)) i_grp (
        .a_i   (a_i[LSB +: GW]),
        .b_i   (b_i[LSB +: GW]),
        .ci_i  (grp_c[g]),
        .sum_o (sum_o[LSB +: GW]),
        .co_o  (grp_c[g+1]),
        .z_co_o(grp_z[g]),
        .o_co_o(grp_o[g])
      );
    end
  end

  assign cout_o = grp_c[NG];

endmodule

// File: rtl/csel_add_chk.sv
`timescale 1ns/1ps
module csel_add_chk #(
  parameter int                  W     = 16,
  parameter csel_pkg::grp_mode_e MODE  = csel_pkg::GRP_SQRT,
  parameter int                  LIN_W = 4,
  parameter int                  NG    = 5
) (
  input logic [W-1:0]  a_i,
  input logic [W-1:0]  b_i,
  input logic          cin_i,
  input logic [W-1:0]  sum_i,
  input logic          cout_i,
  input logic [NG:0]   grp_c_i,
  input logic [NG-1:0] grp_z_i,
  input logic [NG-1:0] grp_o_i
);

  logic [W:0] ref_total;

  always_comb begin
    ref_total = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    // R1
    arith_sum_chk: assert ({cout_i, sum_i} == ref_total);
    // R6
    low_bit_chk: assert (sum_i[0] == (a_i[0] ^ b_i[0] ^ cin_i));
    // R8
    full_prop_chk: assert (!(cin_i && (&(a_i ^ b_i))) || (sum_i == '0 && cout_i));
  end

  for (genvar g = 0; g < NG; g++) begin : g_chk
    localparam int LSB = csel_pkg::grp_lsb(W, MODE, LIN_W, g);
    localparam int GW  = csel_pkg::grp_wid(W, MODE, LIN_W, g);
    logic [GW:0] slice_ref;
    logic        all_prop;
    always_comb begin
      slice_ref = {1'b0, a_i[LSB +: GW]} + {1'b0, b_i[LSB +: GW]} + {{GW{1'b0}}, grp_c_i[g]};
      all_prop  = &(a_i[LSB +: GW] ^ b_i[LSB +: GW]);
      // R2 R3 R5
      grp_slice_chk: assert ({grp_c_i[g+1], sum_i[LSB +: GW]} == slice_ref);
      if (g > 0) begin
        // R4
        one_carry_chk: assert (grp_o_i[g] == (grp_z_i[g] | all_prop));
        // R4
        zero_imp_one_chk: assert (!grp_z_i[g] || grp_o_i[g]);
      end
    end
  end

endmodule

bind csel_add csel_add_chk #(
  .W    (W),
  .MODE (MODE),
  .LIN_W(LIN_W),
  .NG   (NG)
) i_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .sum_i  (sum_o),
  .cout_i (cout_o),
  .grp_c_i(grp_c),
  .grp_z_i(grp_z),
  .grp_o_i(grp_o)
);

// File: tb/test_csel_add.sv
`timescale 1ns/1ps
module test_csel_add;
  import csel_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        op_c = 1'b0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [15:0] s_sq16, s_lin16, s_lin16d, s_sq16d;
  logic [4:0]  s_sq5;
  logic [3:0]  s_lin4;
  logic [12:0] s_lin13;
  logic [63:0] s_sq64, s_lin64;
  logic c_sq16, c_lin16, c_lin16d, c_sq16d, c_sq5, c_lin4, c_lin13, c_sq64, c_lin64;

  csel_add i_csel_add (.a_i(op_a[15:0]), .b_i(op_b[15:0]), .cin_i(op_c), .sum_o(s_sq16), .cout_o(c_sq16));
  csel_add #(.W(16), .MODE(GRP_LINEAR), .LIN_W(4)) u_lin16 (
    .a_i(op_a[15:0]), .b_i(op_b[15:0]), .cin_i(op_c), .sum_o(s_lin16), .cout_o(c_lin16));
  csel_add #(.W(16), .MODE(GRP_LINEAR), .LIN_W(4), .VARIANT(SEL_DUAL)) u_lin16d (
    .a_i(op_a[15:0]), .b_i(op_b[15:0]), .cin_i(op_c), .sum_o(s_lin16d), .cout_o(c_lin16d));
  csel_add #(.W(16), .MODE(GRP_SQRT), .VARIANT(SEL_DUAL)) u_sq16d (
    .a_i(op_a[15:0]), .b_i(op_b[15:0]), .cin_i(op_c), .sum_o(s_sq16d), .cout_o(c_sq16d));
  csel_add #(.W(5), .MODE(GRP_SQRT)) u_sq5 (
    .a_i(op_a[4:0]), .b_i(op_b[4:0]), .cin_i(op_c), .sum_o(s_sq5), .cout_o(c_sq5));
  csel_add #(.W(4), .MODE(GRP_LINEAR), .LIN_W(4)) u_lin4 (
    .a_i(op_a[3:0]), .b_i(op_b[3:0]), .cin_i(op_c), .sum_o(s_lin4), .cout_o(c_lin4));
  csel_add #(.W(13), .MODE(GRP_LINEAR), .LIN_W(4)) u_lin13 (
    .a_i(op_a[12:0]), .b_i(op_b[12:0]), .cin_i(op_c), .sum_o(s_lin13), .cout_o(c_lin13));
  csel_add #(.W(64), .MODE(GRP_SQRT)) u_sq64 (
    .a_i(op_a), .b_i(op_b), .cin_i(op_c), .sum_o(s_sq64), .cout_o(c_sq64));
  csel_add #(.W(64), .MODE(GRP_LINEAR), .LIN_W(8)) u_lin64 (
    .a_i(op_a), .b_i(op_b), .cin_i(op_c), .sum_o(s_lin64), .cout_o(c_lin64));

  task automatic chk(string who, string req, int w, logic [64:0] got);
    logic [64:0] msk;
    logic [64:0] a_m;
    logic [64:0] b_m;
    logic [64:0] exp;
    msk = (65'd1 << (w + 1)) - 65'd1;
    a_m = {1'b0, op_a} & (msk >> 1);
    b_m = {1'b0, op_b} & (msk >> 1);
    exp = (a_m + b_m + {64'd0, op_c}) & msk;
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h (a=%h b=%h c=%b)", who, req, got, exp, op_a, op_b, op_c);
    end
  endtask

  task automatic chk_eq(string who, logic [16:0] got, logic [16:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s R7: got %h expected %h", who, got, exp);
    end
  endtask

  task automatic check_all(string req);
    chk("sq16",   {req, " R3"}, 16, 65'({c_sq16, s_sq16}));
    chk("lin16",  {req, " R2"}, 16, 65'({c_lin16, s_lin16}));
    chk("lin16d", {req, " R2"}, 16, 65'({c_lin16d, s_lin16d}));
    chk("sq16d",  {req, " R3"}, 16, 65'({c_sq16d, s_sq16d}));
    chk("sq5",    {req, " R3"}, 5,  65'({c_sq5, s_sq5}));
    chk("lin4",   {req, " R2"}, 4,  65'({c_lin4, s_lin4}));
    chk("lin13",  {req, " R2"}, 13, 65'({c_lin13, s_lin13}));
    chk("sq64",   {req, " R3"}, 64, {c_sq64, s_sq64});
    chk("lin64",  {req, " R2"}, 64, {c_lin64, s_lin64});
    // R7: dual-ripple variant against converter variant
    chk_eq("lin16 dual vs bec", {c_lin16d, s_lin16d}, {c_lin16, s_lin16});
    chk_eq("sq16 dual vs bec",  {c_sq16d, s_sq16d},   {c_sq16, s_sq16});
  endtask

  task automatic apply(logic [63:0] a, logic [63:0] b, logic c, string req);
    @(posedge clk);
    op_a = a;
    op_b = b;
    op_c = c;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_ni = 1'b1;
    // R6: carry-in alone enters the lowest group
    apply('0, '0, 1'b1, "R6");
    apply('0, '0, 1'b0, "R1");
    // R4 R5: runs of propagate ones ending at every bit position
    for (int k = 0; k <= 64; k++) begin
      logic [63:0] run;
      run = (k == 64) ? '1 : ((64'd1 << k) - 64'd1);
      apply(run, '0, 1'b1, "R4,R5");
      apply(run, 64'd1, 1'b0, "R4,R5");
    end
    // R5: single generated carry at every bit
    for (int k = 0; k < 64; k++) begin
      apply(64'd1 << k, 64'd1 << k, 1'b0, "R5");
      apply((64'd1 << k) | ~((64'd1 << k) - 64'd1), 64'd1 << k, 1'b0, "R5");
    end
    // R8: full propagation
    apply('1, '0, 1'b1, "R8");
    apply({16{4'hA}}, {16{4'h5}}, 1'b1, "R8");
    apply('0, '1, 1'b1, "R8");
    apply('1, '1, 1'b1, "R1");
    apply('1, '1, 1'b0, "R1");
    // R1: random operands
    for (int i = 0; i < 3000; i++) begin
      apply({$urandom(), $urandom()}, {$urandom(), $urandom()}, 1'($urandom() & 1), "R1");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule